// File: doc/BRIEF.md
# Shared-Location Configuration Register Pair

This block holds two 8-bit configuration bytes that a serial transmitter/receiver consumes: the upper part of a bit-rate divisor and a frame-format control byte. Both bytes sit behind one bus location. A write is steered to one byte or the other by the most significant bit of the written value. A read is steered by timing. A read of the location that follows a cycle with no read of it returns the divisor byte. A read that comes in the cycle right after another read of the location returns the frame-control byte.

The bus side is a simple synchronous port. It has an address-match input, write and read strobes, write data, and registered read data. Both stored bytes are also driven continuously onto outputs for the serial engine.

Top module: `dual_cfg_port`

## Requirements
- R1: After reset, `rateHi` is 0x00, `frameCtl` is 0x86 and `rdData` is 0x00.
- R2: A cycle with `sel`, `wrEn` and `wrData[7]`=0 stores `wrData[3:0]` as the divisor byte. From the next clock edge, `rateHi` shows that nibble with bits 7:4 at 0. `frameCtl` is unchanged.
- R3: A cycle with `sel`, `wrEn` and `wrData[7]`=1 stores `wrData[6:0]` as the frame-control byte. From the next clock edge, `frameCtl` shows those bits with bit 7 at 1. `rateHi` is unchanged.
- R4: A cycle with `sel` and `rdEn`, whose previous cycle had no `sel`&`rdEn`, loads the current `rateHi` value into `rdData` at that clock edge.
- R5: A cycle with `sel` and `rdEn`, whose previous cycle also had `sel`&`rdEn`, loads the current `frameCtl` value into `rdData`. This also holds for the third and later consecutive reads.
- R6: Any cycle without `sel`&`rdEn` ends the read sequence. This includes an idle cycle, a write, and a read strobe with `sel` low. The next selected read returns `rateHi` again.
- R7: Strobes given while `sel` is low have no effect. Neither stored byte changes, and `rdData` keeps its value.
- R8: `rdData` changes only at the edge that ends a selected read cycle. Otherwise it holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Bus address matches this location |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 8 | Write data; bit 7 picks the target byte |
| rdData | output | 8 | Registered read data |
| rateHi | output | 8 | Divisor upper byte (bits 7:4 always 0) |
| frameCtl | output | 8 | Frame-control byte (bit 7 always 1) |

## Verification
Each result is due at the first clock edge after the cycle in which its strobe is presented. Stored-byte updates, the read data and the read-sequence flag all settle after that edge, and no result needs a second register stage. The driver applies one cycle of stimulus at the falling edge and queues the outputs expected right after the next rising edge. The monitor compares all three outputs 1 ns after that rising edge. Read sequences are broken by idle cycles, by writes and by unselected strobes, so that the flag state decides every expected read result.

// File: rtl/dual_cfg_pkg.sv
package dual_cfg_pkg;

  // Strobes from the control half to the register half
  typedef struct packed {
    logic wrRate;   // store divisor nibble
    logic wrFrame;  // store frame-control bits
    logic rdRate;   // load divisor byte into read data
    logic rdFrame;  // load frame-control byte into read data
  } cfgStrobe_t;

endpackage

// File: rtl/dual_cfg_ctrl.sv
module dual_cfg_ctrl
  import dual_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sel,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic       steerBit,
  output cfgStrobe_t strb
);

  logic rdHit;
  logic wrHit;
  logic prevRd;

  assign rdHit = sel & rdEn;
  assign wrHit = sel & wrEn;

  // Remembers whether the location was read in the previous cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevRd <= 1'b0;
    else       prevRd <= rdHit;
  end

  always_comb begin
    strb.wrRate  = wrHit & ~steerBit;
    strb.wrFrame = wrHit &  steerBit;
    strb.rdRate  = rdHit & ~prevRd;
    strb.rdFrame = rdHit &  prevRd;
  end

  // R5: a read directly after a read targets frame control
  assert_back_to_back_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sel && rdEn) |=> ((sel && rdEn) |-> strb.rdFrame));

  // R6: any cycle without a selected read restarts the sequence
  assert_sequence_break_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(sel && rdEn) |=> ((sel && rdEn) |-> strb.rdRate));

  // R7: nothing is strobed while the location is not selected
  assert_unselected_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !sel |-> (strb == '0));

endmodule

// File: rtl/dual_cfg_regs.sv
module dual_cfg_regs
  import dual_cfg_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int RATE_BITS = 4,
  parameter logic [DATA_W-1:0] RATE_RST  = 8'h00,
  parameter logic [DATA_W-1:0] FRAME_RST = 8'h86
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] rateOut,
  output logic [DATA_W-1:0] frameOut
);

  localparam int FRAME_W = DATA_W - 1;
  localparam int PAD_W   = DATA_W - RATE_BITS;

  logic [RATE_BITS-1:0] rateQ;
  logic [FRAME_W-1:0]   frameQ;
  logic [DATA_W-1:0]    rdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateQ <= RATE_RST[RATE_BITS-1:0];
    end else if (strb.wrRate) begin
      rateQ <= wrData[RATE_BITS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameQ <= FRAME_RST[FRAME_W-1:0];
    end else if (strb.wrFrame) begin
      frameQ <= wrData[FRAME_W-1:0];
    end
  end

  assign rateOut  = {{PAD_W{1'b0}}, rateQ};
  assign frameOut = {1'b1, frameQ};

  // Read data register: loads the pre-edge contents of the chosen byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdQ <= '0;
    end else if (strb.rdFrame) begin
      rdQ <= frameOut;
    end else if (strb.rdRate) begin
      rdQ <= rateOut;
    end
  end

  assign rdData = rdQ;

  // R2: divisor write lands at the next edge
  assert_rate_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrRate |=> (rateOut == {{PAD_W{1'b0}}, $past(wrData[RATE_BITS-1:0])}));

  // R3: frame-control write lands at the next edge with its top bit set
  assert_frame_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrFrame |=> (frameOut == {1'b1, $past(wrData[FRAME_W-1:0])}));

  // R3: frame-control byte holds when not written
  assert_frame_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrFrame |=> $stable(frameOut));

  // R2: divisor byte holds when not written
  assert_rate_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrRate |=> $stable(rateOut));

  // R4: lone read returns the divisor byte
  assert_lone_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdRate |=> (rdData == $past(rateOut)));

  // R5: follow-on read returns frame control
  assert_next_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdFrame |=> (rdData == $past(frameOut)));

  // R8: read data only moves on a read
  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.rdRate || strb.rdFrame) |=> $stable(rdData));

endmodule

// File: rtl/dual_cfg_port.sv
module dual_cfg_port
  import dual_cfg_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int RATE_BITS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] rateHi,
  output logic [DATA_W-1:0] frameCtl
);

  localparam int STEER_IDX = DATA_W - 1;

  cfgStrobe_t strb;

  dual_cfg_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sel      (sel),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .steerBit (wrData[STEER_IDX]),
    .strb     (strb)
  );

  dual_cfg_regs #(
    .DATA_W    (DATA_W),
    .RATE_BITS (RATE_BITS)
  ) i_regs (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (wrData),
    .rdData   (rdData),
    .rateOut  (rateHi),
    .frameOut (frameCtl)
  );

endmodule

// File: tb/test_dual_cfg_port.sv
`timescale 1ns/1ps
module test_dual_cfg_port;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sel = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic [7:0] rateHi;
  logic [7:0] frameCtl;

  always #2 clk = ~clk;

  dual_cfg_port i_dual_cfg_port (
    .clk(clk), .rstN(rstN), .sel(sel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .rateHi(rateHi), .frameCtl(frameCtl)
  );

  typedef struct {
    logic [7:0] rate;
    logic [7:0] frame;
    logic [7:0] rd;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit monOn = 1'b0;

  // Reference model, built from the requirements
  logic [7:0] mRate = 8'h00;
  logic [7:0] mFrame = 8'h86;
  logic [7:0] mRd = 8'h00;
  bit         mPrev = 1'b0;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  // Driver: one bus cycle, expected outputs queued for the following edge
  task automatic cyc(input logic s, input logic w, input logic r, input logic [7:0] d, input string tag);
    expItem_t e;
    @(negedge clk);
    sel = s; wrEn = w; rdEn = r; wrData = d;
    if (s && r) mRd = mPrev ? mFrame : mRate;
    if (s && w) begin
      if (d[7]) mFrame = {1'b1, d[6:0]};
      else      mRate  = {4'h0, d[3:0]};
    end
    mPrev = s && r;
    e.rate = mRate; e.frame = mFrame; e.rd = mRd; e.tag = tag;
    expQ.push_back(e);
  endtask

  // Monitor: compares 1 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (monOn && expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        check(e.tag, rateHi, e.rate, "rateHi");
        check(e.tag, frameCtl, e.frame, "frameCtl");
        check(e.tag, rdData, e.rd, "rdData");
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    check("R1", rateHi, 8'h00, "rateHi");
    check("R1", frameCtl, 8'h86, "frameCtl");
    check("R1", rdData, 8'h00, "rdData");
    @(negedge clk);
    rstN = 1'b1;
    monOn = 1'b1;

    cyc(1, 0, 0, 8'h00, "R1 idle");
    // R2: divisor writes, upper bits dropped
    cyc(1, 1, 0, 8'h05, "R2 write 05");
    cyc(1, 1, 0, 8'h7A, "R2 write 7A");
    // R3: frame writes
    cyc(1, 1, 0, 8'h95, "R3 write 95");
    cyc(1, 1, 0, 8'h80, "R3 write 80");
    cyc(1, 1, 0, 8'hC3, "R3 write C3");
    cyc(0, 0, 0, 8'h00, "R8 idle hold");
    // R4: lone reads
    cyc(1, 0, 1, 8'h00, "R4 lone read");
    cyc(0, 0, 0, 8'h00, "R8 idle");
    cyc(1, 1, 0, 8'h09, "R2 write 09");
    cyc(0, 0, 0, 8'h00, "R8 idle");
    cyc(1, 0, 1, 8'h00, "R4 lone read after write");
    cyc(0, 0, 0, 8'h00, "R8 idle");
    // R5: consecutive reads
    cyc(1, 0, 1, 8'h00, "R5 first of three");
    cyc(1, 0, 1, 8'h00, "R5 second of three");
    cyc(1, 0, 1, 8'h00, "R5 third of three");
    // R6: idle breaks sequence
    cyc(0, 0, 0, 8'h00, "R6 idle gap");
    cyc(1, 0, 1, 8'h00, "R6 read after idle");
    // R6: write breaks sequence
    cyc(1, 1, 0, 8'h8F, "R6 write gap");
    cyc(1, 0, 1, 8'h00, "R6 read after write");
    cyc(1, 0, 1, 8'h00, "R5 read after read");
    // R6/R7: unselected read breaks sequence and does not load
    cyc(0, 0, 1, 8'h00, "R7 unselected read");
    cyc(1, 0, 1, 8'h00, "R6 read after unselected read");
    // R7: unselected writes ignored
    cyc(0, 1, 0, 8'h03, "R7 unselected rate write");
    cyc(0, 1, 0, 8'hFF, "R7 unselected frame write");
    cyc(1, 0, 1, 8'h00, "R7 read divisor");
    cyc(1, 0, 1, 8'h00, "R7 read frame");
    cyc(0, 0, 0, 8'h00, "R8 final hold");
    cyc(0, 0, 0, 8'h00, "R8 final hold");
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule